// File: doc/BRIEF.md
# Weight Tile Prefetch Queue

This block sits between the off-chip weight memory port and the path that loads shadow weights into a square matrix-multiply array. Weight data arrives as fixed 64-byte chunks, at most one per cycle. The block packs the chunks into complete N×N tiles of 8-bit weights and keeps up to four finished tiles, so that fetching weights does not hold up computation in the array.

The array raises a one-cycle pulse when a weight switch has travelled to the end of its first row. The block then sends the oldest complete tile out, one row of N weights per cycle, into the array's free weight buffers. A tile's storage slot becomes free only after its last row has been sent. While all four slots are occupied, incoming chunks are refused with backpressure. A drain request that arrives when no complete tile is held raises an error pulse, and no rows are produced.

Top module: `weight_tile_fifo`

## Requirements
- R1: Tile byte b sits at row b/N, column b%N. Chunk k of a tile carries tile bytes 64k to 64k+63, with its byte i in bits [8i+7:8i]. On output, column c of a row is in rowData bits [8c+7:8c].
- R2: A tile counts as complete, and tileCount rises by one, at the clock edge that accepts the N*N/64-th chunk of that tile. A tile that has only some of its chunks is not counted.
- R3: tileCount never exceeds 4. tileFull is high when it equals 4, and chunkReady is then low. Chunks presented while the queue is full are neither stored nor counted.
- R4: When switchDone is high at an edge with no drain in progress and tileCount > 0, rowValid is high for exactly N consecutive cycles starting the next cycle. rowIndex runs 0 to N-1 during those cycles, and the oldest tile is sent first.
- R5: tileCount and tileFull hold steady during a drain. The slot is released, and tileCount falls by one, at the edge that ends the last row.
- R6: When switchDone is high at an edge with no drain in progress and tileCount = 0, underflowErr is high for exactly the next cycle and rowValid stays low.
- R7: switchDone while a drain is in progress has no effect. The row sequence carries on unchanged and no underflow is raised.
- R8: If a tile completes at the same edge as another tile's last row, tileCount is left unchanged.
- R9: After reset, tileCount = 0, tileEmpty = 1, tileFull = 0, chunkReady = 1, rowValid = 0 and underflowErr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chunkValid | input | 1 | A weight chunk is offered |
| chunkData | input | 512 | 64-byte weight chunk, byte 0 in the low bits |
| chunkReady | output | 1 | Chunk is accepted at this edge if chunkValid is high |
| switchDone | input | 1 | Switch reached the end of the first array row; requests a drain |
| rowValid | output | 1 | A tile row is presented on rowData |
| rowIndex | output | 4 | Index of the row being presented |
| rowData | output | 128 | N weights of the current row, column 0 in the low bits |
| tileCount | output | 3 | Number of complete tiles held |
| tileFull | output | 1 | All four slots hold complete tiles |
| tileEmpty | output | 1 | No complete tile is held |
| underflowErr | output | 1 | One-cycle pulse after a drain request with no tile |

## Verification
The bench fills the queue to four tiles and then keeps offering chunks. A design that leaked these chunks would either corrupt the next tile's packing or go past the count limit, and the later contents checks would catch it. It issues drain requests on an empty queue and on a partly filled tile; a design that counted partial tiles would stream garbage rows instead of flagging an underflow. It holds switchDone high through a whole drain to catch a design that restarts the row sequence, and it lands a tile completion on the same edge as a last row to catch a count that loses one of the two updates. Row contents are checked against a byte pattern that depends on the tile, so a design that drains out of order or mixes up chunk offsets shows a mismatch.

// File: rtl/wtf_pkg.sv
package wtf_pkg;
  // Geometry of the array and of the memory port
  localparam int ArrayN      = 16;
  localparam int ChunkBytes  = 64;
  localparam int Slots       = 4;

  // Derived sizes (ArrayN*ArrayN must be a multiple of ChunkBytes)
  localparam int RowBits       = ArrayN * 8;
  localparam int ChunkBits     = ChunkBytes * 8;
  localparam int TileBytes     = ArrayN * ArrayN;
  localparam int TileBits      = TileBytes * 8;
  localparam int ChunksPerTile = TileBytes / ChunkBytes;
  localparam int SlotW         = (Slots > 1) ? $clog2(Slots) : 1;
  localparam int CountW        = $clog2(Slots + 1);
  localparam int ChunkIdxW     = (ChunksPerTile > 1) ? $clog2(ChunksPerTile) : 1;
  localparam int RowIdxW       = (ArrayN > 1) ? $clog2(ArrayN) : 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic [SlotW-1:0]     wrSlot;
    logic [ChunkIdxW-1:0] wrChunk;
    logic [SlotW-1:0]     rdSlot;
    logic [RowIdxW-1:0]   rdRow;
  } ctrlStrobes_t;
endpackage

// File: rtl/wtf_datapath.sv
module wtf_datapath
  import wtf_pkg::*;
(
  input  logic                 clk,
  input  ctrlStrobes_t         strobes,
  input  logic [ChunkBits-1:0] chunkData,
  output logic [RowBits-1:0]   rowData
);

  logic [TileBits-1:0] tileMem [Slots];

  // One storage slot per tile; chunks land at their row-major byte offset
  for (genvar s = 0; s < Slots; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (strobes.wrSlot == SlotW'(s))) begin
        tileMem[s][int'(strobes.wrChunk)*ChunkBits +: ChunkBits] <= chunkData;
      end
    end
  end

  // Row select out of the head slot
  always_comb begin
    rowData = tileMem[strobes.rdSlot][int'(strobes.rdRow)*RowBits +: RowBits];
  end

endmodule

// File: rtl/wtf_ctrl.sv
module wtf_ctrl
  import wtf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               chunkValid,
  input  logic               switchDone,
  output ctrlStrobes_t       strobes,
  output logic               chunkReady,
  output logic               rowValid,
  output logic [RowIdxW-1:0] rowIndex,
  output logic [CountW-1:0]  tileCount,
  output logic               tileFull,
  output logic               tileEmpty,
  output logic               underflowErr
);

  logic [SlotW-1:0]     wrPtr, rdPtr;
  logic [ChunkIdxW-1:0] fillIdx;
  logic [RowIdxW-1:0]   rowIdx;
  logic                 draining;
  logic                 accept, tileDone, drainStart, drainEnd, drainMiss;

  function automatic logic [SlotW-1:0] nextSlot(input logic [SlotW-1:0] p);
    return (p == SlotW'(Slots - 1)) ? '0 : p + 1'b1;
  endfunction

  assign tileFull   = (tileCount == CountW'(Slots));
  assign tileEmpty  = (tileCount == '0);
  assign chunkReady = !tileFull;

  assign accept     = chunkValid && !tileFull;
  assign tileDone   = accept && (fillIdx == ChunkIdxW'(ChunksPerTile - 1));
  assign drainStart = switchDone && !draining && !tileEmpty;
  assign drainMiss  = switchDone && !draining && tileEmpty;
  assign drainEnd   = draining && (rowIdx == RowIdxW'(ArrayN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fillIdx      <= '0;
      rowIdx       <= '0;
      draining     <= 1'b0;
      tileCount    <= '0;
      underflowErr <= 1'b0;
    end else begin
      underflowErr <= drainMiss;
      if (accept) begin
        if (tileDone) begin
          fillIdx <= '0;
          wrPtr   <= nextSlot(wrPtr);
        end else begin
          fillIdx <= fillIdx + 1'b1;
        end
      end
      if (drainStart) begin
        draining <= 1'b1;
        rowIdx   <= '0;
      end else if (drainEnd) begin
        draining <= 1'b0;
        rowIdx   <= '0;
        rdPtr    <= nextSlot(rdPtr);
      end else if (draining) begin
        rowIdx <= rowIdx + 1'b1;
      end
      tileCount <= tileCount + CountW'(tileDone) - CountW'(drainEnd);
    end
  end

  assign rowValid = draining;
  assign rowIndex = rowIdx;

  always_comb begin
    strobes         = '0;
    strobes.wrEn    = accept;
    strobes.wrSlot  = wrPtr;
    strobes.wrChunk = fillIdx;
    strobes.rdSlot  = rdPtr;
    strobes.rdRow   = rowIdx;
  end

  // Checks on the control state
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    tileCount <= CountW'(Slots));

  p_drain_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (switchDone && !rowValid && !tileEmpty) |=> (rowValid && rowIndex == '0));

  p_row_seq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowIndex != RowIdxW'(ArrayN - 1)) |=>
      (rowValid && rowIndex == $past(rowIndex) + 1'b1));

  p_hold_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rowValid && rowIndex != RowIdxW'(ArrayN - 1)) |=> (tileCount >= $past(tileCount)));

  p_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (switchDone && !rowValid && tileEmpty) |=> (underflowErr && !rowValid));

  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    tileEmpty |-> !rowValid);

endmodule

// File: rtl/weight_tile_fifo.sv
module weight_tile_fifo
  import wtf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 chunkValid,
  input  logic [ChunkBits-1:0] chunkData,
  output logic                 chunkReady,
  input  logic                 switchDone,
  output logic                 rowValid,
  output logic [RowIdxW-1:0]   rowIndex,
  output logic [RowBits-1:0]   rowData,
  output logic [CountW-1:0]    tileCount,
  output logic                 tileFull,
  output logic                 tileEmpty,
  output logic                 underflowErr
);

  ctrlStrobes_t strobes;

  wtf_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .chunkValid   (chunkValid),
    .switchDone   (switchDone),
    .strobes      (strobes),
    .chunkReady   (chunkReady),
    .rowValid     (rowValid),
    .rowIndex     (rowIndex),
    .tileCount    (tileCount),
    .tileFull     (tileFull),
    .tileEmpty    (tileEmpty),
    .underflowErr (underflowErr)
  );

  wtf_datapath u_datapath (
    .clk       (clk),
    .strobes   (strobes),
    .chunkData (chunkData),
    .rowData   (rowData)
  );

endmodule

// File: tb/weight_tile_fifo_bench.sv
module weight_tile_fifo_bench;
  import wtf_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 chunkValid = 1'b0;
  logic [ChunkBits-1:0] chunkData = '0;
  logic                 switchDone = 1'b0;
  logic                 chunkReady, rowValid, tileFull, tileEmpty, underflowErr;
  logic [RowIdxW-1:0]   rowIndex;
  logic [RowBits-1:0]   rowData;
  logic [CountW-1:0]    tileCount;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;  // 50 MHz

  weight_tile_fifo u_weight_tile_fifo (
    .clk(clk), .rstN(rstN), .chunkValid(chunkValid), .chunkData(chunkData),
    .chunkReady(chunkReady), .switchDone(switchDone), .rowValid(rowValid),
    .rowIndex(rowIndex), .rowData(rowData), .tileCount(tileCount),
    .tileFull(tileFull), .tileEmpty(tileEmpty), .underflowErr(underflowErr)
  );

  // Stimulus table: op 0 = push tile, op 1 = drain and compare; expCount after the op
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] seed;
    logic [2:0] expCount;
  } vec_t;
  localparam int NumVecs = 10;
  localparam vec_t Vecs [NumVecs] = '{
    '{2'd0, 8'd1, 3'd1}, '{2'd0, 8'd2, 3'd2}, '{2'd1, 8'd1, 3'd1},
    '{2'd0, 8'd3, 3'd2}, '{2'd0, 8'd4, 3'd3}, '{2'd0, 8'd5, 3'd4},
    '{2'd1, 8'd2, 3'd3}, '{2'd1, 8'd3, 3'd2}, '{2'd1, 8'd4, 3'd1},
    '{2'd1, 8'd5, 3'd0}
  };

  // Expected weight for byte b of tile seed (R1 layout model)
  function automatic logic [7:0] wByte(input int seed, input int b);
    return 8'(seed * 29 + b * 3 + b / 16);
  endfunction

  function automatic logic [ChunkBits-1:0] mkChunk(input int seed, input int k);
    logic [ChunkBits-1:0] c;
    for (int i = 0; i < ChunkBytes; i++) c[i*8 +: 8] = wByte(seed, k * ChunkBytes + i);
    return c;
  endfunction

  function automatic logic [RowBits-1:0] mkRow(input int seed, input int r);
    logic [RowBits-1:0] v;
    for (int c = 0; c < ArrayN; c++) v[c*8 +: 8] = wByte(seed, r * ArrayN + c);
    return v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [RowBits-1:0] act,
                       input logic [RowBits-1:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one edge, then settle to a sampling point mid-cycle
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic pushChunks(input int seed, input int first, input int count);
    for (int k = first; k < first + count; k++) begin
      chunkValid = 1'b1;
      chunkData  = mkChunk(seed, k);
      tick();
    end
    chunkValid = 1'b0;
  endtask

  // Drain one tile; optionally hold switchDone (R7) or push a tile alongside (R8)
  task automatic drainTile(input int seed, input bit hold, input int pushSeed);
    int pre;
    int exp;
    pre = int'(tileCount);
    switchDone = 1'b1;
    tick();
    switchDone = hold;
    for (int r = 0; r < ArrayN; r++) begin
      check(rowValid == 1'b1, "R4 rowValid", RowBits'(rowValid), 1);
      check(rowIndex == RowIdxW'(r), "R4 rowIndex", RowBits'(rowIndex), RowBits'(r));
      check(rowData == mkRow(seed, r), "R1 rowData", rowData, mkRow(seed, r));
      check(int'(tileCount) == pre, "R5 count held", RowBits'(tileCount), RowBits'(pre));
      if (hold) check(underflowErr == 1'b0, "R7 no underflow", RowBits'(underflowErr), 0);
      if (pushSeed >= 0 && r >= ArrayN - ChunksPerTile) begin
        chunkValid = 1'b1;
        chunkData  = mkChunk(pushSeed, r - (ArrayN - ChunksPerTile));
      end else begin
        chunkValid = 1'b0;
      end
      if (r == ArrayN - 1) switchDone = 1'b0;
      tick();
    end
    chunkValid = 1'b0;
    exp = pre - 1 + ((pushSeed >= 0) ? 1 : 0);
    check(rowValid == 1'b0, "R4 rowValid ends", RowBits'(rowValid), 0);
    check(int'(tileCount) == exp, (pushSeed >= 0) ? "R8 count" : "R5 count drop",
          RowBits'(tileCount), RowBits'(exp));
  endtask

  initial begin
    #2000000;
    failCount++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R9 reset state
    check(tileCount == 0, "R9 count", RowBits'(tileCount), 0);
    check(tileEmpty == 1'b1, "R9 empty", RowBits'(tileEmpty), 1);
    check(tileFull == 1'b0, "R9 full", RowBits'(tileFull), 0);
    check(chunkReady == 1'b1, "R9 ready", RowBits'(chunkReady), 1);
    check(rowValid == 1'b0, "R9 rowValid", RowBits'(rowValid), 0);
    check(underflowErr == 1'b0, "R9 underflow", RowBits'(underflowErr), 0);

    // R6 drain request on an empty queue
    switchDone = 1'b1; tick(); switchDone = 1'b0;
    check(underflowErr == 1'b1, "R6 pulse", RowBits'(underflowErr), 1);
    check(rowValid == 1'b0, "R6 no rows", RowBits'(rowValid), 0);
    tick();
    check(underflowErr == 1'b0, "R6 pulse ends", RowBits'(underflowErr), 0);

    // R2 partial tile is not counted
    pushChunks(7, 0, ChunksPerTile - 1);
    check(tileCount == 0, "R2 partial", RowBits'(tileCount), 0);
    switchDone = 1'b1; tick(); switchDone = 1'b0;
    check(underflowErr == 1'b1, "R2 partial underflow", RowBits'(underflowErr), 1);
    check(rowValid == 1'b0, "R2 partial no rows", RowBits'(rowValid), 0);
    pushChunks(7, ChunksPerTile - 1, 1);
    check(tileCount == 1, "R2 complete", RowBits'(tileCount), 1);
    drainTile(7, 1'b0, -1);

    // Table-driven fill/drain ordering (R1, R2, R4, R5)
    for (int v = 0; v < NumVecs; v++) begin
      if (Vecs[v].op == 2'd0) pushChunks(int'(Vecs[v].seed), 0, ChunksPerTile);
      else drainTile(int'(Vecs[v].seed), 1'b0, -1);
      check(tileCount == CountW'(Vecs[v].expCount), "R2 table count",
            RowBits'(tileCount), RowBits'(Vecs[v].expCount));
    end

    // R3 full queue refuses chunks
    for (int s = 10; s < 14; s++) pushChunks(s, 0, ChunksPerTile);
    check(tileFull == 1'b1, "R3 full", RowBits'(tileFull), 1);
    check(chunkReady == 1'b0, "R3 ready low", RowBits'(chunkReady), 0);
    pushChunks(99, 0, 3);
    check(tileCount == 4, "R3 count capped", RowBits'(tileCount), 4);
    switchDone = 1'b1; tick(); switchDone = 1'b0;
    check(tileFull == 1'b1, "R5 full during drain", RowBits'(tileFull), 1);
    for (int r = 1; r < ArrayN; r++) tick();
    check(tileFull == 1'b1, "R5 full at last row", RowBits'(tileFull), 1);
    tick();
    check(tileFull == 1'b0, "R5 slot freed", RowBits'(tileFull), 0);
    for (int s = 11; s < 14; s++) drainTile(s, 1'b0, -1);
    pushChunks(14, 0, ChunksPerTile);
    drainTile(14, 1'b0, -1);   // R3: refused chunks left packing aligned

    // R7 switchDone held through a drain
    pushChunks(20, 0, ChunksPerTile);
    pushChunks(21, 0, ChunksPerTile);
    drainTile(20, 1'b1, -1);

    // R8 tile completes on the same edge as the last row
    drainTile(21, 1'b0, 22);
    check(tileCount == 1, "R8 net count", RowBits'(tileCount), 1);
    drainTile(22, 1'b0, -1);
    check(tileEmpty == 1'b1, "R9 empty again", RowBits'(tileEmpty), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule